// File: doc/BRIEF.md
# Mark-and-Replay Read Pointer

This block owns the read pointer of a FIFO on the read clock. A consumer can tag the location it is reading with a mark strobe. Later it can issue a one-cycle rewind request that moves the read pointer back to that tagged location, so data already consumed is delivered again. After a rewind, reads go on in order until the pointer catches up with the write pointer, so words written after the rewind are also delivered. The write pointer arrives already synchronized into the read clock domain. The block uses it to stop reads when the FIFO is empty, to count writes made since the mark, and to report the fill level. Flag logic elsewhere takes that fill level, which follows the rewound pointer.

A rewind is only safe if the marked data has not been overwritten. The block therefore allows it only after at least one word has been read since the last reset, and only while the writes made since the mark number no more than the FIFO depth. A request made when these conditions do not hold is dropped. Pointers are `AW+1` bits wide, giving a depth of `2**AW`. A master reset and a partial reset each clear the pointer, the mark and the read history.

Top module: `rtm_replay_ptr`

## Requirements
- R1: While `rst` is high, on the next clock edge `rd_ptr` becomes 0 and `rt_ok` becomes 0. `fill` then equals `wr_ptr`.
- R2: A read is accepted when `rd_req` is high and `rd_ptr` differs from `wr_ptr`. An accepted read, with no rewind in the same cycle, advances `rd_ptr` by one modulo 2**(AW+1). A request made while `rd_ptr` equals `wr_ptr` leaves `rd_ptr` unchanged.
- R3: If `mark` is high in a cycle whose read is accepted, the value of `rd_ptr` before that read is stored as the mark. A `mark` with no accepted read stores nothing.
- R4: If `rt` is high while `rt_ok` is high, `rd_ptr` is loaded with the stored mark on that edge. Any `rd_req` in that same cycle is ignored.
- R5: `rt_ok` is high exactly when two conditions both hold. At least one read has been accepted since the last reset. Also, the count of writes since the mark is at most 2**AW. That count is the sum of per-cycle increases of `wr_ptr` (mod 2**(AW+1)), starting from the cycle of the accepted marked read, or from reset if no mark has been made.
- R6: An `rt` pulse while `rt_ok` is low leaves `rd_ptr` unchanged.
- R7: After a rewind, accepted reads advance `rd_ptr` one step at a time until it equals `wr_ptr`. This includes positions written after the rewind.
- R8: `fill` equals `wr_ptr - rd_ptr` modulo 2**(AW+1). It follows the rewound pointer in the cycle after a rewind.
- R9: `prs` has the same clearing effect as `rst`. After either one, the mark is location 0, so a later permitted rewind returns `rd_ptr` to 0.
- R10: A mark covering a full 2**AW words can be replayed in full, and this can be repeated any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-domain clock |
| rst | input | 1 | Master reset, synchronous, active high |
| prs | input | 1 | Partial reset, synchronous, active high |
| wr_ptr | input | AW+1 | Write pointer, already synchronized into the read domain |
| rd_req | input | 1 | Read request |
| mark | input | 1 | Mark the location of the read made in this cycle |
| rt | input | 1 | Rewind request, one cycle |
| rd_ptr | output | AW+1 | Current read pointer |
| fill | output | AW+1 | Words between the read pointer and the write pointer |
| rt_ok | output | 1 | A rewind is currently permitted |

## Verification
Directed sequences come first. They cover a rewind issued before any read, a mark raised with no read, a mark taken in the middle of a block, and a rewind that coincides with a read request. Together these show whether the rewind target is the marked location or address zero, and whether a rewind gives way to a read or takes priority over it. A further sequence pushes the writes since the mark past the depth. It shows whether the permission limit sits exactly at the depth or one step away. The full-depth replay, repeated twice, and a partial reset followed by a rewind show whether the mark survives a replay and whether it is cleared by a reset. A long pseudo-random run then mixes write bursts, reads, marks, rewinds and partial resets. On every cycle it compares pointer, fill and permission against a behavioural model.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    // Action taken on the read pointer in one cycle
    typedef enum logic [1:0] {
        RD_HOLD   = 2'd0,
        RD_STEP   = 2'd1,
        RD_REWIND = 2'd2
    } rd_act_e;

    // Per-cycle decision carried from the controller to the top
    typedef struct packed {
        rd_act_e act;
        logic    fire;
    } rd_dec_t;

    // Width of a pointer for a given address width
    function automatic int ptr_width(input int aw);
        return aw + 1;
    endfunction

endpackage

// File: rtl/rtm_wr_tracker.sv
module rtm_wr_tracker #(
    parameter int AW = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            restart,
    input  logic [rtm_pkg::ptr_width(AW)-1:0] wr_ptr,
    output logic [rtm_pkg::ptr_width(AW)-1:0] wsm
);
    localparam int PW    = rtm_pkg::ptr_width(AW);
    localparam int DEPTH = 1 << AW;
    localparam int SW    = PW + 2;
    localparam logic [SW-1:0] CAP = SW'(DEPTH + 1);

    logic [PW-1:0] wr_prev;
    logic [PW-1:0] delta;
    logic [SW-1:0] base;
    logic [SW-1:0] sum;
    logic [PW-1:0] wsm_nxt;

    always_comb begin
        delta   = wr_ptr - wr_prev;
        base    = restart ? '0 : {2'b00, wsm};
        sum     = base + {2'b00, delta};
        wsm_nxt = (sum > CAP) ? CAP[PW-1:0] : sum[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_prev <= wr_ptr;
            wsm     <= '0;
        end else begin
            wr_prev <= wr_ptr;
            wsm     <= wsm_nxt;
        end
    end

    // R5
    wsm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !restart && wr_ptr == wr_prev) |=> $stable(wsm));

    // R5
    wsm_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (wsm <= PW'(DEPTH + 1)));

endmodule

// File: rtl/rtm_mark_reg.sv
module rtm_mark_reg #(
    parameter int AW = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            fire,
    input  logic                            mark,
    input  logic [rtm_pkg::ptr_width(AW)-1:0] rd_ptr,
    output logic [rtm_pkg::ptr_width(AW)-1:0] mark_ptr,
    output logic                            seen
);
    localparam int PW = rtm_pkg::ptr_width(AW);

    logic load;
    assign load = fire && mark;

    always_ff @(posedge clk) begin
        if (clr) begin
            mark_ptr <= '0;
            seen     <= 1'b0;
        end else begin
            if (load) mark_ptr <= rd_ptr;
            if (fire) seen     <= 1'b1;
        end
    end

    // R3
    mark_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load) |=> (mark_ptr == $past(rd_ptr)));

    // R3
    mark_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load) |=> $stable(mark_ptr));

    // R5
    seen_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && fire) |=> seen);

endmodule

// File: rtl/rtm_rd_ctrl.sv
module rtm_rd_ctrl #(
    parameter int AW = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            rd_req,
    input  logic                            rt,
    input  logic                            rt_ok,
    input  logic [rtm_pkg::ptr_width(AW)-1:0] mark_ptr,
    input  logic [rtm_pkg::ptr_width(AW)-1:0] wr_ptr,
    output logic [rtm_pkg::ptr_width(AW)-1:0] rd_ptr,
    output rtm_pkg::rd_dec_t                dec
);
    import rtm_pkg::*;
    localparam int PW = ptr_width(AW);

    logic non_empty;

    always_comb begin
        non_empty = (rd_ptr != wr_ptr);
        if (rt && rt_ok)               dec.act = RD_REWIND;
        else if (rd_req && non_empty)  dec.act = RD_STEP;
        else                           dec.act = RD_HOLD;
        dec.fire = (dec.act == RD_STEP);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rd_ptr <= '0;
        end else begin
            unique case (dec.act)
                RD_REWIND: rd_ptr <= mark_ptr;
                RD_STEP:   rd_ptr <= rd_ptr + PW'(1);
                default:   rd_ptr <= rd_ptr;
            endcase
        end
    end

    // R4
    rewind_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && rt && rt_ok) |=> (rd_ptr == $past(mark_ptr)));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(rt && rt_ok) && rd_req && rd_ptr != wr_ptr)
        |=> (rd_ptr == $past(rd_ptr) + PW'(1)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(rt && rt_ok) && !(rd_req && rd_ptr != wr_ptr)) |=> $stable(rd_ptr));

endmodule

// File: rtl/rtm_replay_ptr.sv
module rtm_replay_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prs,
    input  logic [AW:0]   wr_ptr,
    input  logic          rd_req,
    input  logic          mark,
    input  logic          rt,
    output logic [AW:0]   rd_ptr,
    output logic [AW:0]   fill,
    output logic          rt_ok
);
    import rtm_pkg::*;
    localparam int PW    = ptr_width(AW);
    localparam int DEPTH = 1 << AW;

    logic          clr;
    logic [PW-1:0] mark_ptr;
    logic          seen;
    logic [PW-1:0] wsm;
    rd_dec_t       dec;

    assign clr   = rst || prs;
    assign rt_ok = seen && (wsm <= PW'(DEPTH));
    assign fill  = wr_ptr - rd_ptr;

    rtm_rd_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .rd_req   (rd_req),
        .rt       (rt),
        .rt_ok    (rt_ok),
        .mark_ptr (mark_ptr),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .dec      (dec)
    );

    rtm_mark_reg #(.AW(AW)) u_mark (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .fire     (dec.fire),
        .mark     (mark),
        .rd_ptr   (rd_ptr),
        .mark_ptr (mark_ptr),
        .seen     (seen)
    );

    rtm_wr_tracker #(.AW(AW)) u_wtrk (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .restart  (dec.fire && mark),
        .wr_ptr   (wr_ptr),
        .wsm      (wsm)
    );

    // R9
    prs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        prs |=> (rd_ptr == '0 && !rt_ok && mark_ptr == '0));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_ptr == '0 && !rt_ok));

endmodule

// File: tb/sim_rtm_replay_ptr.sv
module sim_rtm_replay_ptr;
    localparam int AW = 4;
    localparam int D  = 1 << AW;
    localparam int M  = 2 * D;

    logic        clk = 1'b0;
    logic        rst = 1'b1, prs = 1'b0, rd_req = 1'b0, mark = 1'b0, rt = 1'b0;
    logic [AW:0] wr_ptr = '0;
    logic [AW:0] rd_ptr, fill;
    logic        rt_ok;

    int checks = 0, errors = 0;
    int m_rd = 0, m_mark = 0, m_seen = 0, m_wsm = 0, m_wprev = 0;
    int w = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtm_replay_ptr #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .prs(prs), .wr_ptr(wr_ptr), .rd_req(rd_req),
        .mark(mark), .rt(rt), .rd_ptr(rd_ptr), .fill(fill), .rt_ok(rt_ok)
    );

    function automatic int cap(input int v);
        return (v > D + 1) ? D + 1 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, step the model, compare at the next falling edge
    task automatic step(input bit r, input bit p, input bit q, input bit mk, input bit t, input string tag);
        int wm, dl, okv;
        wm = w % M;
        rst = r; prs = p; rd_req = q; mark = mk; rt = t; wr_ptr = wm[AW:0];
        if (r || p) begin
            m_rd = 0; m_mark = 0; m_seen = 0; m_wsm = 0; m_wprev = wm;
        end else begin
            dl = (wm - m_wprev + M) % M;
            m_wprev = wm;
            okv = (m_seen != 0) && (m_wsm <= D);
            if (t && okv) begin
                m_rd = m_mark; m_wsm = cap(m_wsm + dl);
            end else if (q && m_rd != wm) begin
                if (mk) begin m_mark = m_rd; m_wsm = cap(dl); end
                else m_wsm = cap(m_wsm + dl);
                m_rd = (m_rd + 1) % M; m_seen = 1;
            end else begin
                m_wsm = cap(m_wsm + dl);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(int'(rd_ptr) == m_rd, tag, "rd_ptr", int'(rd_ptr), m_rd);
        okv = (m_seen != 0) && (m_wsm <= D);
        check(int'(rt_ok) == okv, "R5", "rt_ok", int'(rt_ok), okv);
        check(int'(fill) == (wm - m_rd + M) % M, "R8", "fill", int'(fill), (wm - m_rd + M) % M);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, "R6");           // rewind before any read: ignored
        w = 5; step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R3");            // mark without read: ignored
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 1, 0, "R3");            // mark location 2
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 0, 0, "R2");            // empty: request ignored
        step(0, 0, 0, 0, 1, "R4");            // rewind to 2
        step(0, 0, 1, 0, 0, "R7");
        step(0, 0, 1, 0, 1, "R4");            // rewind wins over read
        w = 7;
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, "R7");
        for (int i = 0; i < 15; i++) begin w++; step(0, 0, 1, 0, 0, "R5"); end
        step(0, 0, 0, 0, 1, "R6");            // more than depth written since mark
        w = 0; step(0, 1, 0, 0, 0, "R9");
        w = 3; step(0, 0, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 1, "R9");            // mark cleared: rewind to 0
        w = 0; step(0, 1, 0, 0, 0, "R9");
        w = 16; step(0, 0, 0, 0, 0, "R10");
        step(0, 0, 1, 1, 0, "R10");
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, "R10");
        for (int k = 0; k < 2; k++) begin
            step(0, 0, 0, 0, 1, "R10");
            for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, "R10");
        end
        for (int i = 0; i < 3000; i++) begin
            int f, inc;
            bit p;
            f = (w % M - m_rd + M) % M;
            inc = $urandom_range(0, 2);
            if (f + inc <= D) w = w + inc;
            p = ($urandom_range(0, 199) == 0);
            if (p) w = 0;
            step(0, p, $urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 19) == 0, "R7");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule